// File: doc/BRIEF.md
# Packing Event Output Buffer

This block sits between an event processor and a bus reader. The processor streams 16-bit words into a first-in first-out store, and each event ends with a marked word. The reader takes the data as 32-bit words, and each 32-bit transfer removes one or two stored words. The block can append a 16-bit checksum to every event, so the reader can recompute it and compare.

The number of complete events not yet read is held in a saturating up/down counter. The counter is separate from the store occupancy. It counts up when the final stored word of an event has been written. It counts down when the reader pulses a done strobe after it has taken a whole event. A ready flag reports a non-zero count. A busy output compares the stored word count against a programmable level, so an upstream trigger can be held off before the store fills.

Both data sides use valid/ready. A write word is taken in a cycle where `in_valid` and `in_ready` are both high. A read word is taken in a cycle where `out_valid` and `out_ready` are both high. While valid is high and ready is low, the offering side must hold its word. Every event must have at least two stored words. With the checksum enabled, this holds for any event of one or more producer words.

Top module: `event_outbuf`

## Requirements
- R1: In each cycle where `in_valid` and `in_ready` are both high, the word on `in_data` is stored. `in_ready` is low when the store holds 2^DEPTH_LOG2 words, and a word offered while full is not stored.
- R2: Each read transfer carries the older stored word in bits [15:0] and the next stored word in bits [31:16]. `out_last` is 1 when the transfer holds the final stored word of an event.
- R3: When the final word of an event would fall in bits [15:0], it is sent alone with bits [31:16] zero. The first word of the next event starts a new transfer in bits [15:0].
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values on the next cycle.
- R5: With CSUM_EN=1, the block stores one extra word after the producer's word marked `in_last`. That extra word is the sum, modulo 2^16, of all producer words of the event, and it is the final stored word of the event. `in_ready` is low in the cycle the extra word is written.
- R6: `evt_count` rises by one on the clock edge that stores an event's final word. This is the checksum word when CSUM_EN=1, and the word marked `in_last` when CSUM_EN=0.
- R7: A one-cycle pulse on `evt_done` lowers `evt_count` by one. An increment and a decrement in the same cycle leave it unchanged.
- R8: `evt_count` saturates at 2^CNT_W-1 on increment and at 0 on decrement.
- R9: `evt_ready` is high exactly when `evt_count` is non-zero.
- R10: `busy` is high exactly when the number of stored words is greater than or equal to `af_level`.
- R11: After reset the store is empty, so `out_valid` is 0, `in_ready` is 1, `evt_count` is 0, `evt_ready` is 0 and `busy` is 0 (for `af_level` greater than 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write word offered |
| in_ready | output | 1 | Write word can be taken |
| in_data | input | 16 | Write word |
| in_last | input | 1 | Write word is the producer's last of the event |
| out_valid | output | 1 | Packed read word available |
| out_ready | input | 1 | Reader takes the packed word |
| out_data | output | 32 | Packed read word |
| out_last | output | 1 | Packed word holds the event's final word |
| evt_done | input | 1 | Reader finished one event (one-cycle pulse) |
| af_level | input | DEPTH_LOG2+1 | Busy threshold in stored words |
| busy | output | 1 | Stored words at or above the threshold |
| evt_ready | output | 1 | At least one unread event |
| evt_count | output | CNT_W | Unread complete events |

## Verification
Packing is tried with events whose stored length is even, which tells apart correct low/high word ordering. It is also tried with odd lengths, which shows whether the zero upper half appears and whether the next event is realigned. Checksums are driven with sums that wrap past 16 bits and with one-word events, so the modular sum is compared with the inserted word. The counter is driven past its maximum, below zero, and with an increment and a decrement in the same cycle. The store is filled to capacity with a word held on the input, and then drained, which shows whether a rejected word ever appears. A second instance without the checksum tells apart counting on the producer's last word from counting on the inserted word.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              last;
    logic [WORD_W-1:0] data;
  } evw_t;
endpackage

// File: rtl/evb_writer.sv
module evb_writer
  import evb_pkg::*;
#(
  parameter bit CSUM_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              has_space,
  output logic              push,
  output evw_t              push_word,
  output logic              evt_closed
);
  generate
    if (CSUM_EN) begin : g_csum
      logic              pend;
      logic [WORD_W-1:0] acc;
      logic              fire;
      logic              csum_wr;

      assign in_ready   = !pend && has_space;
      assign fire       = in_valid && in_ready;
      assign csum_wr    = pend && has_space;
      assign push       = fire || csum_wr;
      assign push_word  = pend ? evw_t'({1'b1, acc}) : evw_t'({1'b0, in_data});
      assign evt_closed = csum_wr;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend <= 1'b0;
          acc  <= '0;
        end else if (csum_wr) begin
          pend <= 1'b0;
          acc  <= '0;
        end else if (fire) begin
          acc  <= acc + in_data;
          pend <= in_last;
        end
      end
    end else begin : g_raw
      assign in_ready   = has_space;
      assign push       = in_valid && has_space;
      assign push_word  = evw_t'({in_last, in_data});
      assign evt_closed = push && in_last;
    end
  endgenerate
endmodule

// File: rtl/evb_store.sv
module evb_store
  import evb_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  evw_t        push_word,
  input  logic [1:0]  pop_cnt,
  output evw_t        head0,
  output evw_t        head1,
  output logic [AW:0] occ,
  output logic        has_space
);
  localparam int DEPTH = 1 << AW;

  evw_t          mem [DEPTH];
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [AW-1:0] rptr_n;

  assign rptr_n    = rptr + AW'(1);
  assign head0     = mem[rptr];
  assign head1     = mem[rptr_n];
  assign has_space = (occ != (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      wptr <= wptr + AW'(push);
      rptr <= rptr + AW'(pop_cnt);
      occ  <= occ + (AW+1)'(push) - (AW+1)'(pop_cnt);
    end
  end
endmodule

// File: rtl/evb_packer.sv
module evb_packer
  import evb_pkg::*;
#(
  parameter int AW = 11
) (
  input  evw_t                head0,
  input  evw_t                head1,
  input  logic [AW:0]         occ,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [2*WORD_W-1:0] out_data,
  output logic                out_last,
  output logic [1:0]          pop_cnt
);
  logic single;

  assign single    = head0.last;
  assign out_valid = (occ >= (AW+1)'(2)) || ((occ == (AW+1)'(1)) && single);
  assign out_data  = single ? {{WORD_W{1'b0}}, head0.data} : {head1.data, head0.data};
  assign out_last  = single || head1.last;
  assign pop_cnt   = (out_valid && out_ready) ? (single ? 2'd1 : 2'd2) : 2'd0;
endmodule

// File: rtl/evb_evcount.sv
module evb_evcount #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             ready
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  assign ready = |cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt != MAXV) cnt <= cnt + CNT_W'(1);
        2'b01:   if (cnt != '0)   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/event_outbuf.sv
module event_outbuf
  import evb_pkg::*;
#(
  parameter int DEPTH_LOG2 = 11,
  parameter int CNT_W      = 12,
  parameter bit CSUM_EN    = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [15:0]           in_data,
  input  logic                  in_last,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [31:0]           out_data,
  output logic                  out_last,
  input  logic                  evt_done,
  input  logic [DEPTH_LOG2:0]   af_level,
  output logic                  busy,
  output logic                  evt_ready,
  output logic [CNT_W-1:0]      evt_count
);
  localparam int AW = DEPTH_LOG2;

  logic        push;
  evw_t        push_word;
  logic        evt_closed;
  logic        has_space;
  evw_t        head0;
  evw_t        head1;
  logic [AW:0] occ;
  logic [1:0]  pop_cnt;

  evb_writer #(.CSUM_EN(CSUM_EN)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .has_space(has_space), .push(push), .push_word(push_word), .evt_closed(evt_closed)
  );

  evb_store #(.AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_word(push_word), .pop_cnt(pop_cnt),
    .head0(head0), .head1(head1), .occ(occ), .has_space(has_space)
  );

  evb_packer #(.AW(AW)) u_pack (
    .head0(head0), .head1(head1), .occ(occ), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .pop_cnt(pop_cnt)
  );

  evb_evcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(evt_closed), .dec(evt_done),
    .cnt(evt_count), .ready(evt_ready)
  );

  assign busy = (occ >= af_level);
endmodule

// File: rtl/evb_checker.sv
module evb_checker #(
  parameter int AW    = 11,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_inc,
  input logic             evt_done,
  input logic [CNT_W-1:0] evt_count,
  input logic             evt_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic             out_last,
  input logic [AW:0]      occ
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= (AW+1)'(1 << AW));

  p_hold_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_inc && !evt_done && (evt_count != MAXV) |=> evt_count == CNT_W'($past(evt_count) + 1'b1));

  p_both_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_inc && evt_done |=> $stable(evt_count));

  p_sat_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_count == MAXV) && evt_inc && !evt_done |=> evt_count == MAXV);

  p_sat_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_count == '0) && evt_done && !evt_inc |=> evt_count == '0);

  p_ready_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_inc && !evt_done |=> evt_ready);
endmodule

bind event_outbuf evb_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_inc(evt_closed), .evt_done(evt_done),
  .evt_count(evt_count), .evt_ready(evt_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .occ(occ)
);

// File: tb/event_outbuf_test.sv
`timescale 1ns/1ps
module event_outbuf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // checksum instance
  logic        a_in_valid = 0, a_in_last = 0, a_out_ready = 0, a_evt_done = 0;
  logic [15:0] a_in_data = 0;
  logic [5:0]  a_af_level = 6'd32;
  logic        a_in_ready, a_out_valid, a_out_last, a_busy, a_evt_ready;
  logic [31:0] a_out_data;
  logic [2:0]  a_evt_count;

  // plain instance
  logic        b_in_valid = 0, b_in_last = 0, b_out_ready = 0;
  logic [15:0] b_in_data = 0;
  logic        b_in_ready, b_out_valid, b_out_last, b_busy, b_evt_ready;
  logic [31:0] b_out_data;
  logic [2:0]  b_evt_count;

  event_outbuf #(.DEPTH_LOG2(5), .CNT_W(3), .CSUM_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(a_in_valid), .in_ready(a_in_ready),
    .in_data(a_in_data), .in_last(a_in_last), .out_valid(a_out_valid),
    .out_ready(a_out_ready), .out_data(a_out_data), .out_last(a_out_last),
    .evt_done(a_evt_done), .af_level(a_af_level), .busy(a_busy),
    .evt_ready(a_evt_ready), .evt_count(a_evt_count)
  );

  event_outbuf #(.DEPTH_LOG2(5), .CNT_W(3), .CSUM_EN(1'b0)) uut_nc (
    .clk(clk), .rst_n(rst_n), .in_valid(b_in_valid), .in_ready(b_in_ready),
    .in_data(b_in_data), .in_last(b_in_last), .out_valid(b_out_valid),
    .out_ready(b_out_ready), .out_data(b_out_data), .out_last(b_out_last),
    .evt_done(1'b0), .af_level(6'd32), .busy(b_busy),
    .evt_ready(b_evt_ready), .evt_count(b_evt_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_a(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      a_in_valid = 1'b1; a_in_data = base + 16'(i); a_in_last = (i == n-1);
      while (!a_in_ready) @(negedge clk);
      @(negedge clk);
    end
    a_in_valid = 1'b0; a_in_last = 1'b0;
  endtask

  task automatic read_a(output logic [31:0] d, output logic l);
    a_out_ready = 1'b1;
    while (!a_out_valid) @(negedge clk);
    d = a_out_data; l = a_out_last;
    @(negedge clk);
    a_out_ready = 1'b0;
  endtask

  task automatic send_b(input int n, input logic [15:0] base);
    for (int i = 0; i < n; i++) begin
      b_in_valid = 1'b1; b_in_data = base + 16'(i); b_in_last = (i == n-1);
      while (!b_in_ready) @(negedge clk);
      @(negedge clk);
    end
    b_in_valid = 1'b0; b_in_last = 1'b0;
  endtask

  task automatic read_b(output logic [31:0] d, output logic l);
    b_out_ready = 1'b1;
    while (!b_out_valid) @(negedge clk);
    d = b_out_data; l = b_out_last;
    @(negedge clk);
    b_out_ready = 1'b0;
  endtask

  task automatic pulse_done();
    a_evt_done = 1'b1;
    @(negedge clk);
    a_evt_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 out_valid", a_out_valid, 0);
    chk("R11 in_ready", a_in_ready, 1);
    chk("R11 evt_count", a_evt_count, 0);
    chk("R11 evt_ready", a_evt_ready, 0);
    chk("R11 busy", a_busy, 0);
  endtask

  task automatic t_even_csum();
    logic [31:0] d; logic l;
    send_a(3, 16'h1111);
    chk("R5 in_ready low during checksum", a_in_ready, 0);
    @(negedge clk);
    chk("R6 count after event", a_evt_count, 1);
    chk("R9 ready set", a_evt_ready, 1);
    read_a(d, l);
    chk("R2 first pair", d, 32'h1112_1111);
    chk("R2 first pair not last", l, 0);
    read_a(d, l);
    chk("R5 checksum in upper half", d, 32'h3336_1113);
    chk("R2 last flag", l, 1);
    pulse_done();
    chk("R7 decrement", a_evt_count, 0);
    chk("R9 ready clear", a_evt_ready, 0);
  endtask

  task automatic t_odd_wrap();
    logic [31:0] d; logic l;
    a_in_valid = 1'b1; a_in_data = 16'hFFFF; a_in_last = 1'b0;
    while (!a_in_ready) @(negedge clk);
    @(negedge clk);
    a_in_data = 16'h0003; a_in_last = 1'b1;
    while (!a_in_ready) @(negedge clk);
    @(negedge clk);
    a_in_valid = 1'b0; a_in_last = 1'b0;
    send_a(1, 16'h0005);
    @(negedge clk);
    read_a(d, l);
    chk("R2 odd event pair", d, 32'h0003_FFFF);
    read_a(d, l);
    chk("R3 padded checksum wrap R5", d, 32'h0000_0002);
    chk("R3 padded last", l, 1);
    read_a(d, l);
    chk("R3 next event realigned", d, 32'h0005_0005);
    chk("R3 next event last", l, 1);
    pulse_done(); pulse_done();
    chk("R7 two decrements", a_evt_count, 0);
  endtask

  task automatic t_stall();
    logic [31:0] d; logic l;
    send_a(2, 16'h0A0A);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R4 valid held", a_out_valid, 1);
      chk("R4 data held", a_out_data, 32'h0A0B_0A0A);
      chk("R4 last held", a_out_last, 0);
      @(negedge clk);
    end
    read_a(d, l);
    read_a(d, l);
    chk("R5 checksum of two", d, 32'h0000_1415);
    pulse_done();
  endtask

  task automatic t_counter();
    logic [31:0] d; logic l;
    send_a(1, 16'h0042);
    @(negedge clk);
    chk("R6 count one", a_evt_count, 1);
    send_a(1, 16'h0043);
    a_evt_done = 1'b1;
    @(negedge clk);
    a_evt_done = 1'b0;
    chk("R7 simultaneous inc and dec", a_evt_count, 1);
    pulse_done();
    chk("R7 dec to zero", a_evt_count, 0);
    pulse_done();
    chk("R8 floor at zero", a_evt_count, 0);
    chk("R9 ready low at zero", a_evt_ready, 0);
    read_a(d, l);
    read_a(d, l);
    chk("R2 drain second", d, 32'h0043_0043);
  endtask

  task automatic t_fill();
    logic [31:0] d; logic l;
    for (int e = 1; e <= 7; e++) send_a(1, 16'h0100 + 16'(e));
    @(negedge clk);
    chk("R8 count seven", a_evt_count, 7);
    send_a(1, 16'h0108);
    @(negedge clk);
    chk("R8 saturate at max", a_evt_count, 7);
    a_af_level = 6'd16; #1;
    chk("R10 busy at level", a_busy, 1);
    a_af_level = 6'd17; #1;
    chk("R10 not busy below level", a_busy, 0);
    a_af_level = 6'd32;
    @(negedge clk);
    for (int e = 9; e <= 16; e++) send_a(1, 16'h0100 + 16'(e));
    @(negedge clk);
    chk("R1 in_ready low when full", a_in_ready, 0);
    chk("R10 busy when full", a_busy, 1);
    a_in_valid = 1'b1; a_in_data = 16'hDEAD; a_in_last = 1'b1;
    repeat (3) @(negedge clk);
    a_in_valid = 1'b0; a_in_last = 1'b0;
    for (int e = 1; e <= 16; e++) begin
      read_a(d, l);
      chk("R1 drained order", d, {16'h0100 + 16'(e), 16'h0100 + 16'(e)});
      chk("R1 drained last", l, 1);
    end
    chk("R1 rejected word not stored", a_out_valid, 0);
  endtask

  task automatic t_plain();
    logic [31:0] d; logic l;
    send_b(2, 16'hA001);
    chk("R6 plain count on last word", b_evt_count, 1);
    send_b(3, 16'hB001);
    chk("R6 plain count two", b_evt_count, 2);
    read_b(d, l);
    chk("R2 plain pair", d, 32'hA002_A001);
    chk("R2 plain last", l, 1);
    read_b(d, l);
    chk("R2 plain odd pair", d, 32'hB002_B001);
    chk("R2 plain odd not last", l, 0);
    read_b(d, l);
    chk("R3 plain pad", d, 32'h0000_B003);
    chk("R3 plain pad last", l, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_even_csum();
    t_odd_wrap();
    t_stall();
    t_counter();
    t_fill();
    t_plain();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule